// File: doc/BRIEF.md
# Block-Framed Serial Pattern Detector

This block watches a one-bit serial stream, takes one bit per clock, and flags every occurrence of the four-bit sequence 1101. The stream is cut into fixed frames of 256 bits, counted from the last synchronous reset. An occurrence counts only when all four of its bits fall inside the same frame.

Two machines cooperate to do this. A free-running position counter gives the index of the current bit inside its frame. A recognizer tracks how much of the pattern has been seen so far. On the last bit of each frame the recognizer is forced back to idle, and this clear wins over its normal transition. The match flag is a Mealy output: it is high in the same cycle as the final pattern bit on the input. Occurrences may overlap inside a frame.

Top module: `framed_pattern_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the position counter goes to 0 and the recognizer goes idle. A partial match seen before the reset never completes afterwards. With the recognizer idle, `matchPulse` is 0 whatever `serIn` is.
- R2: `bitPos` counts up by one on each clock. It wraps from 255 to 0, and the bit sampled during the cycle after reset is at position 0.
- R3: The pattern is received oldest bit first as 1, 1, 0, 1. `matchPulse` is 1 in the cycle where the final 1 is on `serIn`, provided the three bits before it were 1, 1, 0 in the same frame.
- R4: `matchPulse` is 0 in every cycle that does not complete an occurrence of the pattern, and it is never high for two cycles in a row.
- R5: Occurrences may overlap. After a match, the trailing 1 counts as a one-bit partial match, so 1101101 gives two pulses, on its fourth and seventh bits.
- R6: An occurrence whose bits fall in two frames produces no pulse.
- R7: An occurrence that ends on position 255 is reported in that cycle.
- R8: When `bitPos` is 255, the recognizer starts the next frame idle whatever the input. A frame ending in 110 followed by a 1 at position 0 gives no pulse.
- R9: An occurrence in positions 0 to 3 of a frame is reported at position 3.
- R10: After a mismatch the recognizer falls back to the longest partial match still valid. 111101 reports on its last bit, and 11001101 reports only on its last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every edge consumes one serial bit |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data bit for the current cycle |
| matchPulse | output | 1 | High for the cycle in which the pattern completes (Mealy) |
| bitPos | output | 8 | Position of the current bit inside its 256-bit frame |

## Verification
The bench goes after the frame edges. It places a full pattern at positions 252 to 255, and a design that cleared the recognizer one cycle too early would miss that pulse. It splits a pattern across positions 255 and 0 to 2; a recognizer that kept its state across the frame boundary would pulse there. It puts 110 at the end of a frame, where clear dominance matters: if the normal transition beat the clear, a pulse would appear at position 0. It also sends overlapping occurrences, runs of ones and a reset in the middle of a partial match. A recognizer without overlap would drop the second pulse of 1101101. One with a wrong fallback would miss 111101 or report falsely inside 11001101.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  // Strobes from the recognizer control to the progress register
  typedef struct packed {
    logic clrProg;  // return to idle; dominates the load
    logic ldProg;   // load a new progress value
  } progStrobe_t;

  // Length of the longest prefix of the pattern that ends the received
  // string after inBit arrives, given curLen bits already matched.
  // The pattern is held MSB = oldest bit. With properOnly set, a full
  // match is not accepted, which gives the state kept after a hit.
  function automatic int unsigned fpd_next_len(
    input int unsigned curLen,
    input logic        inBit,
    input int unsigned pattern,
    input int unsigned patLen,
    input bit          properOnly
  );
    int unsigned cand;
    int unsigned best;
    cand = ((pattern >> (patLen - curLen)) << 1) | {31'd0, inBit};
    best = 0;
    for (int unsigned j = 1; j <= 16; j++) begin
      if ((j <= curLen + 1) && (j <= patLen) && !(properOnly && (j == patLen))) begin
        if ((cand & ((32'd1 << j) - 32'd1)) == (pattern >> (patLen - j))) begin
          best = j;
        end
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/fpd_datapath.sv
module fpd_datapath
  import fpd_pkg::*;
#(
  parameter int BLOCK_LEN = 256,
  parameter int PAT_LEN   = 4,
  localparam int POS_W    = $clog2(BLOCK_LEN),
  localparam int PROG_W   = $clog2(PAT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  progStrobe_t       strobes,
  input  logic [PROG_W-1:0] ldVal,
  output logic              blockEnd,
  output logic [PROG_W-1:0] progress,
  output logic [POS_W-1:0]  posCnt
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLOCK_LEN - 1);
  localparam bit POW2 = ((BLOCK_LEN & (BLOCK_LEN - 1)) == 0);

  assign blockEnd = (posCnt == LAST_POS);

  // Position counter: natural wrap for power-of-two frames, compare otherwise
  generate
    if (POW2) begin : g_wrapNatural
      always_ff @(posedge clk) begin
        if (rst) posCnt <= '0;
        else     posCnt <= posCnt + POS_W'(1);
      end
    end else begin : g_wrapCompare
      always_ff @(posedge clk) begin
        if (rst)           posCnt <= '0;
        else if (blockEnd) posCnt <= '0;
        else               posCnt <= posCnt + POS_W'(1);
      end
    end
  endgenerate

  // Progress register: a small counter whose synchronous clear dominates
  always_ff @(posedge clk) begin
    if (rst)                  progress <= '0;
    else if (strobes.clrProg) progress <= '0;
    else if (strobes.ldProg)  progress <= ldVal;
  end

  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    (posCnt != LAST_POS) |=> (posCnt == $past(posCnt) + POS_W'(1))); // R2
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (posCnt == LAST_POS) |=> (posCnt == '0)); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> ((posCnt == '0) && (progress == '0))); // R1

endmodule

// File: rtl/fpd_ctrl.sv
module fpd_ctrl
  import fpd_pkg::*;
#(
  parameter int          PAT_LEN = 4,
  parameter int unsigned PATTERN = 32'hD,
  localparam int         PROG_W  = $clog2(PAT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  logic              blockEnd,
  input  logic [PROG_W-1:0] progress,
  output progStrobe_t       strobes,
  output logic [PROG_W-1:0] ldVal,
  output logic              matchHit
);

  // Partial match kept after a full hit (overlap support)
  localparam int unsigned FALLBACK =
    fpd_next_len(PAT_LEN - 1, PATTERN[0], PATTERN, PAT_LEN, 1'b1);

  int unsigned lenFull;
  int unsigned lenKeep;

  always_comb begin
    lenFull  = fpd_next_len(32'(progress), serIn, PATTERN, PAT_LEN, 1'b0);
    lenKeep  = fpd_next_len(32'(progress), serIn, PATTERN, PAT_LEN, 1'b1);
    matchHit = (lenFull == 32'(PAT_LEN));
    ldVal    = PROG_W'(lenKeep);
    strobes.clrProg = blockEnd;
    strobes.ldProg  = (ldVal != progress);
  end

  AST_HIT_STATE: assert property (@(posedge clk) disable iff (rst)
    matchHit |-> (progress == PROG_W'(PAT_LEN - 1))); // R3
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
    blockEnd |=> (progress == '0)); // R8
  AST_OVERLAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (matchHit && !blockEnd) |=> (progress == PROG_W'(FALLBACK))); // R5
  AST_PROG_RANGE: assert property (@(posedge clk) disable iff (rst)
    (32'(progress) < 32'(PAT_LEN))); // R10

  generate
    if (FALLBACK < PAT_LEN - 1) begin : g_noBackToBack
      AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        matchHit |=> !matchHit); // R4
    end
  endgenerate

endmodule

// File: rtl/framed_pattern_detector.sv
module framed_pattern_detector
  import fpd_pkg::*;
#(
  parameter int          BLOCK_LEN = 256,
  parameter int          PAT_LEN   = 4,
  parameter int unsigned PATTERN   = 32'hD,
  localparam int         POS_W     = $clog2(BLOCK_LEN),
  localparam int         PROG_W    = $clog2(PAT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serIn,
  output logic             matchPulse,
  output logic [POS_W-1:0] bitPos
);

  progStrobe_t       strobes;
  logic [PROG_W-1:0] ldVal;
  logic [PROG_W-1:0] progress;
  logic              blockEnd;

  fpd_ctrl #(
    .PAT_LEN (PAT_LEN),
    .PATTERN (PATTERN)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .serIn    (serIn),
    .blockEnd (blockEnd),
    .progress (progress),
    .strobes  (strobes),
    .ldVal    (ldVal),
    .matchHit (matchPulse)
  );

  fpd_datapath #(
    .BLOCK_LEN (BLOCK_LEN),
    .PAT_LEN   (PAT_LEN)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .ldVal    (ldVal),
    .blockEnd (blockEnd),
    .progress (progress),
    .posCnt   (bitPos)
  );

endmodule

// File: tb/tb_framed_pattern_detector.sv
module tb_framed_pattern_detector;

  localparam int BLOCK = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serIn = 1'b0;
  logic       matchPulse;
  logic [7:0] bitPos;

  always #2 clk = ~clk;  // 250 MHz

  framed_pattern_detector dut (
    .clk        (clk),
    .rst        (rst),
    .serIn      (serIn),
    .matchPulse (matchPulse),
    .bitPos     (bitPos)
  );

  typedef struct {
    int    pos;
    bit    hit;
    string tag;
  } expItem_t;

  expItem_t   expQ[$];
  int         checks = 0;
  int         errors = 0;
  int         refPos = 0;
  logic [3:0] refHist = 4'b0;
  string      curTag = "R3";
  bit         done = 1'b0;

  task automatic check(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Driver: reference model pushes the expectation, then the bit is applied
  task automatic driveBit(input logic b);
    expItem_t e;
    e.pos = refPos;
    e.hit = (refPos >= 3) && ({refHist[2:0], b} == 4'b1101);
    e.tag = curTag;
    expQ.push_back(e);
    refHist = {refHist[2:0], b};
    refPos  = (refPos + 1) % BLOCK;
    serIn   = b;
    @(posedge clk);
    #1;
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) driveBit(bits[i]);
  endtask

  task automatic zerosUntil(input int p);
    while (refPos != p) driveBit(1'b0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    serIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    refPos = 0;
    refHist = 4'b0;
    serIn = 1'b1;
    #1;
    check("R1", int'(bitPos), 0, "bitPos after reset");
    check("R1", int'(matchPulse), 0, "match while idle");
  endtask

  // Monitor: compares outputs mid-cycle against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, int'(matchPulse), int'(e.hit), "matchPulse");
        check("R2", int'(bitPos), e.pos, "bitPos");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    doReset();
    curTag = "R9";  sendBits(32'b1101, 4);
    curTag = "R4";  sendBits(32'b00, 2);
    curTag = "R5";  sendBits(32'b1101101, 7);
    curTag = "R10"; sendBits(32'b111101, 6);
    curTag = "R10"; sendBits(32'b11001101, 8);
    curTag = "R3";  sendBits(32'b01101, 5);
    curTag = "R4";  zerosUntil(252);
    curTag = "R7";  sendBits(32'b1101, 4);
    curTag = "R4";  zerosUntil(253);
    curTag = "R8";  sendBits(32'b110, 3);
    curTag = "R8";  sendBits(32'b1101, 4);
    curTag = "R4";  zerosUntil(255);
    curTag = "R6";  driveBit(1'b1);
    curTag = "R6";  sendBits(32'b101, 3);
    curTag = "R6";  sendBits(32'b1101, 4);
    curTag = "R5";
    for (int k = 0; k < 300; k++) begin
      driveBit(lfsr[0]);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    curTag = "R1";  sendBits(32'b110, 3);
    doReset();
    curTag = "R1";  driveBit(1'b1);
    curTag = "R1";  sendBits(32'b101, 3);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule